// File: doc/BRIEF.md
# Queued SPI Master with Per-Command Delays

This block is an SPI master that works through a small queue of commands. Each command holds one transmit byte and two flags. One flag asks for a programmable wait between chip select going active and the first clock edge. The other asks for a programmable idle gap after the transfer. The received byte of each command is stored in a receive queue at the same index. Software loads the commands and sets the two delay values, the first and last queue index and a wrap option. It then sets the run bit and waits for the done flag. The hardware clears the run bit when the last command is finished or when a fault aborts the queue.

A write to the pointer register is held in a shadow copy until the transfer in progress ends. The shadow's first index is then where execution continues. Reads of that register always show the pointers in force. The serial clock is the system clock divided by four. Frames use mode 0 timing: the clock idles low, data in is sampled on the rising edge, and data out changes on the falling edge, MSB first.

Top module: `qspi_delay_seq`

## Requirements
- R1: After reset, or whenever the run bit is clear and no command is in progress, `pins_oe` is 0, `cs_n` is 1 and `sck` is 0. No transfer starts while the run bit is clear.
- R2: A frame is 8 bits, MSB first, with `sck` high for 2 and low for 2 system clocks. `mosi` changes after a falling `sck` edge and `miso` is sampled at the rising edge. The received byte goes to receive entry k when command k is sent.
- R3: If command bit 8 is set, the number of clocks from `cs_n` falling to the first `sck` rise equals the lead field of register 0x00, where 0 means 128. If bit 8 is clear, the number is 2.
- R4: If command bit 9 is set, `cs_n` stays high for 32 times the trail field of register 0x00 before the next command, where 0 means 8192 clocks. If bit 9 is clear, it stays high for 2 clocks.
- R5: Commands run from the first index to the last index in ascending order. After the last command, the run bit clears, `done` sets and `cs_n` goes high.
- R6: With wrap (register 0x01 bit 15) set, the command after the last index is entry 0. The run bit stays set and `done` stays 0.
- R7: Writes to register 0x01 are held in a shadow copy, and reads of 0x01 return the pointers in force. The shadow takes effect when the current transfer ends, and the next command is the shadow's first index. When the block is idle, the shadow takes effect one clock after the write.
- R8: If `fault_n` is low at a clock edge while the run bit is set, the transfer is aborted. `cs_n` goes high, the run bit clears, and `fault` sets and stays set. The receive entry is not written. If the fault falls in the same cycle as the end of the last command, `done` stays 0.
- R9: Register 0x02 reads `done` in bit 0 and `fault` in bit 1. Writing a 1 to either bit clears that flag.
- R10: Register 0x00 holds the run bit in bit 0, the lead field in bits 7:1 and the trail field in bits 15:8, and reads back as written. Register 0x01 holds the first index in bits 2:0, the last index in bits 10:8 and wrap in bit 15. Command entry i is at 0x40+i, with the transmit byte in bits 7:0 and the flags in bits 8 and 9, and reads back as written. Receive entry i is read at 0x80+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Read data for `rd_addr`, combinational |
| fault_n | input | 1 | Active-low fault request |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| pins_oe | output | 1 | High while the block owns the serial pins |
| done | output | 1 | Sticky queue-complete flag |
| fault | output | 1 | Sticky fault flag |

## Verification
A fault and the end of the last command can land on the same clock edge. The bench counts the exact edge of the final falling `sck` from the run-bit write and holds `fault_n` low only for that edge. It then expects `fault` set, `done` still clear and the receive entry unchanged. A pointer write and an active transfer also overlap: the write is issued while `cs_n` is low. The bench expects the old pointers to read back until the frame ends, and then expects the new first index to be the next command.

// File: rtl/qspi_delay_seq.sv
module qspi_delay_seq #(
  parameter int QDEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [7:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic        fault_n,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic        cs_n,
  output logic        pins_oe,
  output logic        done,
  output logic        fault
);
  localparam int PW = $clog2(QDEPTH);
  localparam int CW = 14;
  localparam logic [CW-1:0] HALF = CW'(2);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL} st_t;

  st_t st;
  logic [9:0] cmdq [QDEPTH];
  logic [7:0] rxq [QDEPTH];
  logic en;
  logic [6:0] lead_r;
  logic [7:0] trail_r;
  logic [PW-1:0] a_start, a_end, s_start, s_end, cur;
  logic a_wrap, s_wrap, pend;
  logic [CW-1:0] cnt;
  logic [7:0] sh, rx;
  logic [2:0] bc;
  logic hc;

  wire [9:0] ccmd = cmdq[cur];
  wire [CW-1:0] lead_len = ccmd[8] ? ((lead_r == '0) ? CW'(128) : CW'(lead_r)) : HALF;
  wire [CW-1:0] trail_len = ccmd[9] ? ((trail_r == '0) ? CW'(8192) : {1'b0, trail_r, 5'd0}) : HALF;
  wire boundary = (st == S_SHIFT) && hc && sck && (bc == 3'd7);
  wire abort = en && !fault_n;
  wire last = (cur == a_end) && !a_wrap;
  wire [PW-1:0] nxt = (cur == a_end || cur == PW'(QDEPTH-1)) ? '0 : cur + 1'b1;
  wire wr_cmd = wr_en && wr_addr[7:6] == 2'b01 && {2'b00, wr_addr[5:0]} < 8'(QDEPTH);

  assign pins_oe = en || (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (wr_cmd) cmdq[wr_addr[PW-1:0]] <= wr_data[9:0];
    if (boundary && !abort) rxq[cur] <= rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; en <= 1'b0; lead_r <= '0; trail_r <= '0;
      a_start <= '0; a_end <= '0; a_wrap <= 1'b0;
      s_start <= '0; s_end <= '0; s_wrap <= 1'b0; pend <= 1'b0;
      cur <= '0; cnt <= '0; sh <= '0; rx <= '0; bc <= '0; hc <= 1'b0;
      sck <= 1'b0; mosi <= 1'b0; cs_n <= 1'b1; done <= 1'b0; fault <= 1'b0;
    end else begin
      if (wr_en && wr_addr == 8'h02) begin
        if (wr_data[0]) done <= 1'b0;
        if (wr_data[1]) fault <= 1'b0;
      end
      if (st != S_IDLE && !en) begin
        st <= S_IDLE; cs_n <= 1'b1; sck <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            if (pend) begin
              a_start <= s_start; a_end <= s_end; a_wrap <= s_wrap; pend <= 1'b0;
            end else if (en) begin
              cur <= a_start; cnt <= CW'(1); st <= S_TRAIL;
            end
          end
          S_TRAIL: begin
            if (cnt == CW'(1)) begin
              cs_n <= 1'b0; mosi <= ccmd[7]; sh <= ccmd[7:0];
              cnt <= lead_len; st <= S_LEAD;
            end else cnt <= cnt - 1'b1;
          end
          S_LEAD: begin
            if (cnt == CW'(1)) begin
              sck <= 1'b1; rx <= {rx[6:0], miso};
              hc <= 1'b0; bc <= '0; st <= S_SHIFT;
            end else cnt <= cnt - 1'b1;
          end
          S_SHIFT: begin
            if (!hc) hc <= 1'b1;
            else begin
              hc <= 1'b0;
              if (sck) begin
                sck <= 1'b0;
                if (bc == 3'd7) begin
                  cs_n <= 1'b1;
                  if (pend) begin
                    a_start <= s_start; a_end <= s_end; a_wrap <= s_wrap; pend <= 1'b0;
                    cur <= s_start; cnt <= trail_len; st <= S_TRAIL;
                  end else if (last) begin
                    en <= 1'b0; done <= 1'b1; st <= S_IDLE;
                  end else begin
                    cur <= nxt; cnt <= trail_len; st <= S_TRAIL;
                  end
                end else begin
                  bc <= bc + 1'b1; mosi <= sh[6]; sh <= {sh[6:0], 1'b0};
                end
              end else begin
                sck <= 1'b1; rx <= {rx[6:0], miso};
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
      if (wr_en && wr_addr == 8'h00) begin
        en <= wr_data[0]; lead_r <= wr_data[7:1]; trail_r <= wr_data[15:8];
      end
      if (wr_en && wr_addr == 8'h01) begin
        s_start <= wr_data[PW-1:0]; s_end <= wr_data[PW+7:8]; s_wrap <= wr_data[15]; pend <= 1'b1;
      end
      if (abort) begin
        en <= 1'b0; st <= S_IDLE; cs_n <= 1'b1; sck <= 1'b0; fault <= 1'b1;
        if (boundary && last && !pend) done <= done;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == 8'h00) rd_data = {trail_r, lead_r, en};
    else if (rd_addr == 8'h01) begin
      rd_data[PW-1:0] = a_start; rd_data[PW+7:8] = a_end; rd_data[15] = a_wrap;
    end else if (rd_addr == 8'h02) rd_data[1:0] = {fault, done};
    else if ({2'b00, rd_addr[5:0]} < 8'(QDEPTH)) begin
      if (rd_addr[7:6] == 2'b01) rd_data[9:0] = cmdq[rd_addr[PW-1:0]];
      else if (rd_addr[7:6] == 2'b10) rd_data[7:0] = rxq[rd_addr[PW-1:0]];
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n) !pins_oe |-> (cs_n && !sck)); // R1
  AST_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ($fell(sck) && !cs_n) |-> $past(sck, 2)); // R2
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n) ($rose(done) && !$past(wr_en && wr_addr == 8'h00)) |-> !en); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (st == S_LEAD || st == S_TRAIL) |=> ($stable(a_start) && $stable(a_end) && $stable(a_wrap))); // R7
  AST_FAULT_ABORT: assert property (@(posedge clk) disable iff (!rst_n) abort |=> (!en && cs_n && fault)); // R8
endmodule

// File: tb/qspi_delay_seq_test.sv
module qspi_delay_seq_test;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, wr_en = 0, fault_n = 1, miso = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic sck, mosi, cs_n, pins_oe, done, fault;
  int tests = 0, fails = 0;

  qspi_delay_seq uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fault_n(fault_n), .miso(miso), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .pins_oe(pins_oe), .done(done), .fault(fault));

  always #(PERIOD/2) clk = ~clk;

  logic [7:0] mlog [0:255];
  int leadl [0:255], gapl [0:255];
  int xc = 0, hic = 0, leadc = 0, nf = 0, hrun = 0, wbad = 0;
  logic pcs = 1, psck = 0, seen = 0, wchk = 1;
  logic [7:0] msr = 0;

  function automatic logic [7:0] sb(input int k);
    return 8'((k * 37 + 11) ^ (k << 3));
  endfunction
  function automatic int exp_lead(input logic [9:0] c, input int ld);
    return c[8] ? (ld == 0 ? 128 : ld) : 2;
  endfunction
  function automatic int exp_gap(input logic [9:0] c, input int tr);
    return c[9] ? (tr == 0 ? 8192 : 32 * tr) : 2;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && pcs) begin gapl[xc] = hic; leadc = 0; seen = 0; nf = 0; msr = 0; end
      if (cs_n && !pcs) begin mlog[xc] = msr; leadl[xc] = leadc; xc++; hic = 0; end
      if (cs_n) hic++;
      if (!cs_n && !seen && !sck) leadc++;
      if (sck) hrun++;
      if (sck && !psck) begin seen = 1; msr = {msr[6:0], mosi}; end
      if (!sck && psck) begin nf++; if (wchk && hrun != 2) wbad++; hrun = 0; end
      miso = (nf < 8) ? sb(xc)[7 - nf] : 1'b0;
      pcs = cs_n; psck = sck;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask
  function automatic logic [15:0] pw(input int s, input int e, input logic w);
    logic [15:0] d = 0;
    d[2:0] = 3'(s); d[10:8] = 3'(e); d[15] = w;
    return d;
  endfunction

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [9:0] cmd [8];
    logic [15:0] d;
    int x0, ld, tr, s, n, e;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && !pins_oe && !done && !fault, "R1 reset pins", {cs_n, sck, pins_oe}, 4);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      cmd[i] = {2'b00, 8'(8'h13 + i * 8'h22)};
      wr(8'h40 + 8'(i), {6'b0, cmd[i]});
    end
    rd(8'h45, d); chk(d[9:0] == cmd[5], "R10 cmd readback", d, cmd[5]);
    wr(8'h00, 16'h0a14);
    rd(8'h00, d); chk(d == 16'h0a14, "R10 reg0 readback", d, 16'h0a14);
    repeat (40) @(negedge clk);
    chk(xc == 0 && cs_n && !sck && !pins_oe, "R1 idle while run bit clear", xc, 0);

    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < 8; i++) begin
        cmd[i] = {2'($urandom), 8'($urandom)};
        wr(8'h40 + 8'(i), {6'b0, cmd[i]});
      end
      ld = 1 + int'($urandom % 20); tr = 1 + int'($urandom % 3);
      s = int'($urandom % 8); n = 1 + int'($urandom % (8 - s)); e = s + n - 1;
      wr(8'h01, pw(s, e, 0)); repeat (2) @(negedge clk);
      rd(8'h01, d); chk(d == pw(s, e, 0), "R7 idle pointer apply", d, pw(s, e, 0));
      x0 = xc;
      wr(8'h00, {8'(tr), 7'(ld), 1'b1});
      while (!done) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(xc == x0 + n, "R5 transfer count", xc - x0, n);
      rd(8'h00, d); chk(done && !d[0] && cs_n, "R5 done and run cleared", d[0], 0);
      for (int j = 0; j < n; j++) begin
        chk(mlog[x0 + j] == cmd[s + j][7:0], "R2 mosi byte", mlog[x0 + j], cmd[s + j][7:0]);
        chk(leadl[x0 + j] == exp_lead(cmd[s + j], ld), "R3 lead delay", leadl[x0 + j], exp_lead(cmd[s + j], ld));
        if (j > 0) chk(gapl[x0 + j] == exp_gap(cmd[s + j - 1], tr), "R4 trail gap", gapl[x0 + j], exp_gap(cmd[s + j - 1], tr));
        rd(8'h80 + 8'(s + j), d); chk(d[7:0] == sb(x0 + j), "R2 rx entry", d[7:0], sb(x0 + j));
      end
      wr(8'h02, 16'h0001);
      chk(!done, "R9 done clear", done, 0);
    end
    chk(wbad == 0, "R2 sck high width", wbad, 0);

    for (int i = 0; i < 8; i++) begin
      cmd[i] = {2'b11, 8'(8'h5a ^ i)};
      wr(8'h40 + 8'(i), {6'b0, cmd[i]});
    end
    wr(8'h01, pw(0, 1, 0)); repeat (2) @(negedge clk);
    x0 = xc; wr(8'h00, 16'h0001);
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(leadl[x0] == 128, "R3 lead zero means 128", leadl[x0], 128);
    chk(gapl[x0 + 1] == 8192, "R4 trail zero means 8192", gapl[x0 + 1], 8192);
    wr(8'h02, 16'h0001);

    for (int i = 0; i < 8; i++) begin
      cmd[i] = {2'b00, 8'(8'h10 + i * 8'h11)};
      wr(8'h40 + 8'(i), {6'b0, cmd[i]});
    end
    wr(8'h01, pw(5, 6, 1)); repeat (2) @(negedge clk);
    x0 = xc; wr(8'h00, 16'h0001);
    while (xc < x0 + 5) @(negedge clk);
    rd(8'h00, d); chk(d[0] && !done, "R6 run stays set on wrap", d[0], 1);
    wr(8'h00, 16'h0000); repeat (6) @(negedge clk);
    chk(cs_n && !pins_oe, "R1 stop on run clear", cs_n, 1);
    chk(mlog[x0 + 1] == cmd[6][7:0] && mlog[x0 + 2] == cmd[0][7:0], "R6 wrap to 0", mlog[x0 + 2], cmd[0][7:0]);
    chk(mlog[x0 + 4] == cmd[2][7:0], "R6 wrap order", mlog[x0 + 4], cmd[2][7:0]);

    wr(8'h01, pw(0, 7, 0)); repeat (2) @(negedge clk);
    x0 = xc; wr(8'h00, 16'h0001);
    while (cs_n) @(negedge clk);
    wr(8'h01, pw(4, 5, 0));
    rd(8'h01, d); chk(d == pw(0, 7, 0), "R7 read shows active", d, pw(0, 7, 0));
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(xc == x0 + 3, "R7 restart count", xc - x0, 3);
    chk(mlog[x0 + 1] == cmd[4][7:0] && mlog[x0 + 2] == cmd[5][7:0], "R7 restart at new index", mlog[x0 + 1], cmd[4][7:0]);
    rd(8'h01, d); chk(d == pw(4, 5, 0), "R7 new pointers", d, pw(4, 5, 0));
    wr(8'h02, 16'h0001);

    wchk = 0;
    wr(8'h01, pw(0, 3, 0)); repeat (2) @(negedge clk);
    x0 = xc; wr(8'h00, 16'h0001);
    while (cs_n) @(negedge clk);
    repeat (10) @(negedge clk);
    fault_n = 0; @(negedge clk); fault_n = 1; @(negedge clk);
    rd(8'h00, d);
    chk(cs_n && !sck && fault && !done && !d[0], "R8 fault abort", {fault, done, d[0]}, 4);
    repeat (40) @(negedge clk);
    chk(xc == x0 + 1, "R8 no further transfers", xc - x0, 1);
    rd(8'h02, d); chk(d[1:0] == 2'b10, "R9 status bits", d[1:0], 2);
    wr(8'h02, 16'h0002); chk(!fault, "R9 fault clear", fault, 0);

    wr(8'h01, pw(3, 3, 0)); repeat (2) @(negedge clk);
    rd(8'h83, d);
    wr(8'h00, 16'h0001);
    repeat (33) @(posedge clk);
    @(negedge clk); fault_n = 0; @(negedge clk); fault_n = 1; @(negedge clk);
    chk(fault && !done && cs_n, "R8 fault beats completion", {fault, done}, 2);
    rd(8'h83, wr_data); chk(wr_data[7:0] == d[7:0], "R8 rx not stored", wr_data[7:0], d[7:0]);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule